// File: doc/BRIEF.md
# Priority Interrupt Controller with Supply-Loss Restart

This block gathers twelve interrupt sources, remembers each one as pending from the rising edge of its request line, and presents exactly one of them to the processor at a time. The processor sees a request flag, the number of the winning source, its priority level, and the address of its service entry point. The processor retires the presented interrupt by pulsing an acknowledge. A processor-driven inhibit holds back ordinary sources. Three critical sources always get through: the supply-loss/restart interrupt (source 0), the program-fault interrupt (source 1) and the self-test-failure interrupt (source 2).

Source 0 has no request pin. It is raised inside the block when a supply-out-of-limits indication has stayed asserted for longer than a parameterized number of clock cycles, or when an external test input rises. Either trigger also drives a system reset output. That output stays high while the supply is still bad and for a fixed number of cycles after the supply recovers. When the reset ends, the source-0 interrupt is still pending, so the processor restarts through the level-0 entry point. The controller's own state is cleared only by its asynchronous reset input, never by the system reset it generates.

Top module: `pri_intc`

## Requirements
- R1: A rising edge on request line i (i from 1 to 11) makes source i pending. The source stays pending until it is acknowledged. A request line that is held high does not make its source pending again after the acknowledge.
- R2: The lowest-numbered eligible pending source is presented. Its level, irq_level, is the source number divided by 3, so sources 0–2 are level 0 (the highest), sources 3–5 are level 1, sources 6–8 are level 2 and sources 9–11 are level 3.
- R3: irq_vec equals 0x0100 plus twice irq_src.
- R4: An acknowledge while irq_req is high clears the pending state of the presented source. The next eligible pending source appears in the cycle after that clock edge. irq_req drops if no eligible source remains.
- R5: While inhibit is high, sources 3 to 11 are not presented but stay pending, and they appear once inhibit falls. Sources 0, 1 and 2 are unaffected by inhibit.
- R6: supply_bad must be sampled high on 9 consecutive rising clock edges (the persistence parameter of 8, plus one) before source 0 is raised. A run of 8 or fewer has no effect.
- R7: The clock edge that raises source 0 also sets sys_reset, so both are visible in the following cycle.
- R8: sys_reset stays high at every clock edge where supply_bad is sampled high. It falls at the 4th rising edge at which supply_bad is sampled low after it was raised.
- R9: A rising edge of test_force raises source 0 and sys_reset without any supply event. sys_reset falls at the 4th rising edge after the trigger edge. Holding test_force high does not trigger again.
- R10: After sys_reset falls, source 0 is still presented with vector 0x0100 until it is acknowledged.
- R11: While rst_n is low, and after it is released, irq_req and sys_reset are 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_in | input | 11 | Request lines for sources 1 to 11 (bit i belongs to source i) |
| inhibit | input | 1 | Holds back every source except 0, 1 and 2 |
| ack | input | 1 | Retires the presented source |
| supply_bad | input | 1 | Supply-out-of-limits indication, synchronous to clk |
| test_force | input | 1 | Test input; a rising edge raises source 0 |
| irq_req | output | 1 | An eligible source is pending |
| irq_src | output | 4 | Number of the presented source |
| irq_level | output | 2 | Priority level of the presented source |
| irq_vec | output | 16 | Service entry address of the presented source |
| sys_reset | output | 1 | Hardware system reset request |

## Verification
The bench targets the persistence threshold with a run of supply_bad exactly one cycle too short and then with a run just long enough. A counter that is off by one would either trip on the short run or react one cycle late. It counts the cycles sys_reset stays high after the supply recovers and after a held test_force. A wrong hold count shows up as a reset that is too short or too long, and a level-sensitive force input would retrigger the reset. It masks with inhibit while critical and ordinary sources are pending together. A design that drops masked requests would never present them afterwards, and one that masks source 1 or 2 would present nothing. Finally, it acknowledges while a request line is still held high, where a level-latched design would present the same source again.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Level of a source: sources are split into equal, consecutive groups.
  function automatic int unsigned src_level(input int unsigned idx,
                                            input int unsigned n_src,
                                            input int unsigned n_lvl);
    int unsigned per_lvl;
    per_lvl = (n_src + n_lvl - 1) / n_lvl;
    return idx / per_lvl;
  endfunction

endpackage

// File: rtl/intc_pf_monitor.sv
module intc_pf_monitor #(
  parameter int unsigned PF_PERSIST = 8,
  parameter int unsigned RST_HOLD   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_bad,
  input  logic test_force,
  output logic trig,
  output logic sys_reset
);
  localparam int unsigned PW = $clog2(PF_PERSIST + 2);
  localparam int unsigned HW = $clog2(RST_HOLD + 1);

  logic [PW-1:0] persist_q, persist_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          force_q;
  logic          active_q, active_d;
  logic          trip;

  // Trip on the edge where the run of bad samples first exceeds PF_PERSIST.
  assign trip = supply_bad && (persist_q == PW'(PF_PERSIST));
  assign trig = trip | (test_force & ~force_q);

  always_comb begin
    persist_d = persist_q;
    if (!supply_bad)
      persist_d = '0;
    else if (persist_q <= PW'(PF_PERSIST))
      persist_d = persist_q + 1'b1;
  end

  always_comb begin
    active_d = active_q;
    hold_d   = hold_q;
    if (trig) begin
      active_d = 1'b1;
      hold_d   = HW'(RST_HOLD);
    end else if (active_q) begin
      if (supply_bad) begin
        hold_d = HW'(RST_HOLD);
      end else if (hold_q == HW'(1)) begin
        active_d = 1'b0;
        hold_d   = '0;
      end else begin
        hold_d = hold_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      persist_q <= '0;
      hold_q    <= '0;
      force_q   <= 1'b0;
      active_q  <= 1'b0;
    end else begin
      persist_q <= persist_d;
      hold_q    <= hold_d;
      force_q   <= test_force;
      active_q  <= active_d;
    end
  end

  assign sys_reset = active_q;

endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int unsigned NUM_SRC = 12,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:1] req_in,
  input  logic               set0,
  input  logic               clr_en,
  input  logic [SRC_W-1:0]   clr_idx,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:1] req_q;
  logic [NUM_SRC-1:0] pend_q, pend_d, set_vec, clr_vec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (i == 0) begin : g_internal
      assign set_vec[i] = set0;
    end else begin : g_external
      assign set_vec[i] = req_in[i] & ~req_q[i];
    end
    assign clr_vec[i] = clr_en && (clr_idx == SRC_W'(i));
    // A fresh edge wins over a clear in the same cycle.
    assign pend_d[i]  = set_vec[i] | (pend_q[i] & ~clr_vec[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_in;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int unsigned          NUM_SRC  = 12,
  parameter int unsigned          NUM_LVL  = 4,
  parameter logic [NUM_SRC-1:0]   NMI_MASK = 'b111,
  localparam int unsigned         SRC_W    = $clog2(NUM_SRC),
  localparam int unsigned         LVL_W    = $clog2(NUM_LVL)
) (
  input  logic [NUM_SRC-1:0] pending,
  input  logic               inhibit,
  output logic               grant_vld,
  output logic [SRC_W-1:0]   grant_idx,
  output logic [LVL_W-1:0]   grant_lvl,
  output logic [NUM_SRC-1:0] grant_oh
);
  import intc_pkg::*;

  logic [NUM_SRC-1:0] eligible;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign eligible[i] = pending[i] & (NMI_MASK[i] | ~inhibit);
  end

  always_comb begin
    grant_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) grant_idx = SRC_W'(i);
    end
  end

  assign grant_vld = |eligible;
  assign grant_lvl = LVL_W'(src_level(int'(grant_idx), NUM_SRC, NUM_LVL));

  always_comb begin
    grant_oh = '0;
    if (grant_vld) grant_oh[grant_idx] = 1'b1;
  end

endmodule

// File: rtl/pri_intc.sv
module pri_intc #(
  parameter int unsigned        NUM_SRC    = 12,
  parameter int unsigned        NUM_LVL    = 4,
  parameter int unsigned        PF_PERSIST = 8,
  parameter int unsigned        RST_HOLD   = 4,
  parameter int unsigned        ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]  VEC_BASE   = 16'h0100,
  parameter logic [NUM_SRC-1:0] NMI_MASK   = 'b111,
  localparam int unsigned       SRC_W      = $clog2(NUM_SRC),
  localparam int unsigned       LVL_W      = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:1] req_in,
  input  logic               inhibit,
  input  logic               ack,
  input  logic               supply_bad,
  input  logic               test_force,
  output logic               irq_req,
  output logic [SRC_W-1:0]   irq_src,
  output logic [LVL_W-1:0]   irq_level,
  output logic [ADDR_W-1:0]  irq_vec,
  output logic               sys_reset
);
  logic [1:0]         rst_sync_q;
  logic               rst_ok_n;
  logic               trig;
  logic               grant_vld;
  logic [SRC_W-1:0]   grant_idx;
  logic [LVL_W-1:0]   grant_lvl;
  logic [NUM_SRC-1:0] grant_oh;
  logic [NUM_SRC-1:0] pend_vec;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  intc_pf_monitor #(
    .PF_PERSIST (PF_PERSIST),
    .RST_HOLD   (RST_HOLD)
  ) u_pf (
    .clk        (clk),
    .rst_n      (rst_ok_n),
    .supply_bad (supply_bad),
    .test_force (test_force),
    .trig       (trig),
    .sys_reset  (sys_reset)
  );

  intc_pending #(
    .NUM_SRC (NUM_SRC)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_ok_n),
    .req_in  (req_in),
    .set0    (trig),
    .clr_en  (ack & grant_vld),
    .clr_idx (grant_idx),
    .pending (pend_vec)
  );

  intc_arbiter #(
    .NUM_SRC  (NUM_SRC),
    .NUM_LVL  (NUM_LVL),
    .NMI_MASK (NMI_MASK)
  ) u_arb (
    .pending   (pend_vec),
    .inhibit   (inhibit),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx),
    .grant_lvl (grant_lvl),
    .grant_oh  (grant_oh)
  );

  assign irq_req   = grant_vld;
  assign irq_src   = grant_idx;
  assign irq_level = grant_lvl;
  assign irq_vec   = VEC_BASE + (ADDR_W'(grant_idx) << 1);

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned        NUM_SRC  = 12,
  parameter int unsigned        SRC_W    = 4,
  parameter logic [NUM_SRC-1:0] NMI_MASK = 'b111
) (
  input logic               clk,
  input logic               rst_ok_n,
  input logic               inhibit,
  input logic               supply_bad,
  input logic               test_force,
  input logic               trig,
  input logic               irq_req,
  input logic [SRC_W-1:0]   irq_src,
  input logic               sys_reset,
  input logic [NUM_SRC-1:0] grant_oh,
  input logic               pend0
);

  // R5: under inhibit only critical sources reach the processor
  assert_inhibit_gate_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (inhibit && irq_req) |-> NMI_MASK[irq_src]);

  // R2: at most one grant, and it exists exactly when a request is flagged
  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $onehot0(grant_oh) && ((grant_oh != '0) == irq_req));

  // R7: a trigger leaves source 0 pending and the system reset raised
  assert_trigger_effect_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    trig |=> (sys_reset && pend0));

  // R7: the system reset only rises after a trigger
  assert_reset_cause_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $rose(sys_reset) |-> $past(trig));

  // R8: a bad supply keeps the system reset asserted
  assert_hold_while_bad_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (sys_reset && supply_bad) |=> sys_reset);

  // R6: without the test input, a trip needs supply_bad on consecutive edges
  assert_persist_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ($rose(sys_reset) && !$past(test_force)) |-> ($past(supply_bad) && $past(supply_bad, 2)));

endmodule

bind pri_intc intc_checker #(
  .NUM_SRC  (NUM_SRC),
  .SRC_W    (SRC_W),
  .NMI_MASK (NMI_MASK)
) u_chk (
  .clk        (clk),
  .rst_ok_n   (rst_ok_n),
  .inhibit    (inhibit),
  .supply_bad (supply_bad),
  .test_force (test_force),
  .trig       (trig),
  .irq_req    (irq_req),
  .irq_src    (irq_src),
  .sys_reset  (sys_reset),
  .grant_oh   (grant_oh),
  .pend0      (pend_vec[0])
);

// File: tb/pri_intc_test.sv
module pri_intc_test;
  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:1]  req_in;
  logic          inhibit, ack, supply_bad, test_force;
  logic          irq_req, sys_reset;
  logic [3:0]    irq_src;
  logic [1:0]    irq_level;
  logic [15:0]   irq_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pri_intc uut (
    .clk (clk), .rst_n (rst_n), .req_in (req_in), .inhibit (inhibit),
    .ack (ack), .supply_bad (supply_bad), .test_force (test_force),
    .irq_req (irq_req), .irq_src (irq_src), .irq_level (irq_level),
    .irq_vec (irq_vec), .sys_reset (sys_reset)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic expect_src(input string tag, input int src);
    check({tag, " irq_req"}, int'(irq_req), 1);
    check({tag, " irq_src"}, int'(irq_src), src);
    check({tag, " irq_level R2"}, int'(irq_level), src / 3);
    check({tag, " irq_vec R3"}, int'(irq_vec), 'h100 + 2 * src);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_in = '0; inhibit = 1'b0; ack = 1'b0;
    supply_bad = 1'b0; test_force = 1'b0;
    tick(2);
    check("R11 irq_req in reset", int'(irq_req), 0);
    check("R11 sys_reset in reset", int'(sys_reset), 0);
    rst_n = 1'b1;
    tick(3);
    check("R11 irq_req after reset", int'(irq_req), 0);
    check("R11 sys_reset after reset", int'(sys_reset), 0);
  endtask

  task automatic t_priority();
    req_in[9] = 1'b1; req_in[4] = 1'b1; req_in[7] = 1'b1;
    tick();
    req_in = '0;
    expect_src("R2 first of 4/7/9", 4);
    do_ack();
    expect_src("R4 next after ack", 7);
    do_ack();
    expect_src("R4 last pending", 9);
    do_ack();
    check("R4 empty after acks", int'(irq_req), 0);
    req_in[3] = 1'b1; req_in[2] = 1'b1;
    tick();
    req_in = '0;
    expect_src("R2 level0 over level1", 2);
    do_ack();
    expect_src("R2 remaining level1", 3);
    do_ack();
    check("R4 empty again", int'(irq_req), 0);
  endtask

  task automatic t_inhibit();
    inhibit = 1'b1;
    req_in[5] = 1'b1; req_in[1] = 1'b1;
    tick();
    req_in = '0;
    expect_src("R5 critical under inhibit", 1);
    do_ack();
    check("R5 ordinary masked", int'(irq_req), 0);
    tick(3);
    check("R5 still masked", int'(irq_req), 0);
    req_in[2] = 1'b1;
    tick();
    req_in = '0;
    expect_src("R5 self-test source unmasked", 2);
    do_ack();
    inhibit = 1'b0;
    tick();
    expect_src("R5 masked source kept pending", 5);
    do_ack();
    check("R5 empty", int'(irq_req), 0);
  endtask

  task automatic t_edge_hold();
    req_in[6] = 1'b1;
    tick();
    expect_src("R1 latched", 6);
    tick(4);
    expect_src("R1 held without ack", 6);
    do_ack();
    check("R1 held line not relatched", int'(irq_req), 0);
    tick(3);
    check("R1 still clear", int'(irq_req), 0);
    req_in[6] = 1'b0;
    tick();
    req_in[6] = 1'b1;
    tick();
    req_in[6] = 1'b0;
    expect_src("R1 new edge relatches", 6);
    do_ack();
    check("R1 cleared", int'(irq_req), 0);
  endtask

  task automatic t_pf_glitch();
    supply_bad = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      check("R6 short run no irq", int'(irq_req), 0);
      check("R6 short run no reset", int'(sys_reset), 0);
    end
    supply_bad = 1'b0;
    tick(2);
    check("R6 glitch ignored irq", int'(irq_req), 0);
    check("R6 glitch ignored reset", int'(sys_reset), 0);
  endtask

  task automatic t_pf_trip();
    inhibit = 1'b1;
    supply_bad = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      check("R6 before threshold", int'(sys_reset), 0);
    end
    tick();
    check("R7 reset at threshold", int'(sys_reset), 1);
    expect_src("R7 level0 raised", 0);
    for (int k = 1; k <= 5; k++) begin
      tick();
      check("R8 held while bad", int'(sys_reset), 1);
    end
    supply_bad = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      tick();
      check("R8 hold after recovery", int'(sys_reset), 1);
    end
    tick();
    check("R8 released", int'(sys_reset), 0);
    expect_src("R10 restart vector", 0);
    do_ack();
    check("R10 retired", int'(irq_req), 0);
    inhibit = 1'b0;
  endtask

  task automatic t_force();
    test_force = 1'b1;
    tick();
    check("R9 forced reset", int'(sys_reset), 1);
    expect_src("R9 forced level0", 0);
    for (int k = 2; k <= 4; k++) begin
      tick();
      check("R9 forced hold", int'(sys_reset), 1);
    end
    tick();
    check("R9 forced release", int'(sys_reset), 0);
    tick(3);
    check("R9 held input no retrigger", int'(sys_reset), 0);
    test_force = 1'b0;
    do_ack();
    check("R9 retired", int'(irq_req), 0);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_inhibit();
    t_edge_hold();
    t_pf_glitch();
    t_pf_trip();
    t_force();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule